// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This controller steers a PLL-based clock generator from power-on, or from any reset, to running outputs. It waits for the supply to be good. When the reference is a crystal, it also waits for enough oscillator swing. It then counts two stabilization windows: the first in phase-detector reference ticks, the second in feedback ticks. Next it issues a start strobe to the VCO calibration engine and times the calibration window. When calibration ends it enables the outputs in the same cycle. Finally it raises a lock flag once a settling window has passed and the analog lock detector agrees.

There are two kinds of restart. A reset pin or the power-down pin restarts the sequence and pulses a request to reload the register defaults. A pulse on the register reset bit (high, then low) only repeats stabilization and calibration, so the current settings are kept. The ticks are single-cycle strobes in the controller's clock domain, produced by the analog and divider logic outside this block. All inputs are control levels or strobes, so there is no handshaking at the edge of the block.

Top module: `clkgen_pwrup_seq`

## Requirements
- R1: While rst_ni is low, or while pwr_good_i, reset_pin_ni or pdn_ni is low, the state after the next clock edge is HOLD (code 0), with out_en_o and lock_o low. This condition has priority over every other input.
- R2: Leaving HOLD produces load_defaults_o high for exactly one cycle, in the cycle in which the new state first shows.
- R3: In the crystal wait state (code 2), with xtal_sel_i high, the sequencer stays until xtal_ok_i is high. With xtal_sel_i low it moves to code 3 at the next edge.
- R4: The reference wait (code 3) ends on the edge that samples exactly the REF_TICKS-th ref_tick_i pulse, moving to code 4. fb_tick_i pulses have no effect on this count.
- R5: The feedback wait (code 4) ends on the edge that samples exactly the FB_TICKS-th fb_tick_i pulse, moving to code 5. ref_tick_i pulses have no effect on this count.
- R6: On entry to calibration (code 5), cal_start_o is high for exactly one cycle, in the first cycle of that state. Calibration lasts exactly CAL_TICKS ref_tick_i pulses, and out_en_o stays low throughout.
- R7: out_en_o goes high in the same cycle that the state becomes RUN (code 6).
- R8: In RUN, lock_o stays low until LOCK_TICKS ref_tick_i pulses have been counted. After that, lock_o equals lock_det_i as sampled one edge earlier. lock_o is never high while out_en_o is low.
- R9: With the pins released, reg_rst_i high moves any state to SOFT (code 1), with outputs disabled. When reg_rst_i falls, the state becomes code 2 and load_defaults_o stays low.
- R10: Re-entering HOLD discards any partial count, so the next reference wait again needs the full REF_TICKS pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| pwr_good_i | input | 1 | Supply good indication |
| xtal_sel_i | input | 1 | High when the reference is a crystal |
| xtal_ok_i | input | 1 | Crystal amplitude sufficient |
| reset_pin_ni | input | 1 | Active-low reset pin, already synchronized |
| pdn_ni | input | 1 | Active-low power-down pin, already synchronized |
| reg_rst_i | input | 1 | Register reset bit |
| ref_tick_i | input | 1 | One-cycle strobe per phase-detector reference cycle |
| fb_tick_i | input | 1 | One-cycle strobe per feedback cycle |
| lock_det_i | input | 1 | Analog lock-detect indication |
| state_o | output | 3 | Current step code (0 HOLD, 1 SOFT, 2 XTAL, 3 REF wait, 4 FB wait, 5 CAL, 6 RUN) |
| load_defaults_o | output | 1 | One-cycle request to reload register defaults |
| cal_start_o | output | 1 | One-cycle VCO calibration start strobe |
| out_en_o | output | 1 | Clock output enable |
| lock_o | output | 1 | Lock status flag |

## Verification
The assertions assume that every input is synchronous to clk_i, and that the tick strobes are single-cycle pulses whose count is meaningful only in the state that consumes them. They also assume that the count parameters are at least one. The stimulus changes inputs only on the falling clock edge and raises each tick for one cycle, with random idle gaps and random pulses on the tick line that is not being counted. Pin and register resets are applied as levels, and they are held for at least one edge.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_SOFT = 3'd1,
    ST_XTAL = 3'd2,
    ST_REFW = 3'd3,
    ST_FBW  = 3'd4,
    ST_CAL  = 3'd5,
    ST_RUN  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/clkseq_tick_counter.sv
module clkseq_tick_counter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  // Terminal tick: the pulse that brings the count to the limit.
  assign hit_o = en_i && tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (en_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // A finished window always restarts from zero (R4, R10).
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0);
endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
  import clkseq_pkg::*;
#(
  parameter int REF_TICKS = 65536,
  parameter int FB_TICKS  = 65536,
  parameter int CAL_TICKS = 131072,
  parameter int CW        = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          reg_rst_i,
  input  logic          xtal_sel_i,
  input  logic          xtal_ok_i,
  input  logic          hit_i,
  output seq_state_e    state_o,
  output logic          run_next_o,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          use_fb_o,
  output logic [CW-1:0] limit_o,
  output logic          load_o,
  output logic          cal_start_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (hold_i) begin
      state_d = ST_HOLD;
    end else if (state_q == ST_HOLD) begin
      state_d = reg_rst_i ? ST_SOFT : ST_XTAL;
    end else if (reg_rst_i) begin
      state_d = ST_SOFT;
    end else begin
      unique case (state_q)
        ST_SOFT: state_d = ST_XTAL;
        ST_XTAL: if (!xtal_sel_i || xtal_ok_i) state_d = ST_REFW;
        ST_REFW: if (hit_i) state_d = ST_FBW;
        ST_FBW:  if (hit_i) state_d = ST_CAL;
        ST_CAL:  if (hit_i) state_d = ST_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_REFW: limit_o = CW'(REF_TICKS);
      ST_FBW:  limit_o = CW'(FB_TICKS);
      ST_CAL:  limit_o = CW'(CAL_TICKS);
      default: limit_o = '1;
    endcase
  end

  assign cnt_en_o   = (state_q == ST_REFW) || (state_q == ST_FBW) || (state_q == ST_CAL);
  assign use_fb_o   = (state_q == ST_FBW);
  assign cnt_clr_o  = (state_d != state_q);
  assign run_next_o = (state_d == ST_RUN);
  assign state_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HOLD;
      load_o      <= 1'b0;
      cal_start_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      load_o      <= (state_q == ST_HOLD) && (state_d != ST_HOLD);
      cal_start_o <= (state_d == ST_CAL) && (state_q != ST_CAL);
    end
  end

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> state_q == ST_HOLD);
  assert_load_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  assert_cal_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> (state_q == ST_CAL) && ($past(state_q) != ST_CAL));
  assert_soft_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT && !hold_i) |=> !load_o);
endmodule

// File: rtl/clkseq_lock_timer.sv
module clkseq_lock_timer #(
  parameter int LOCK_TICKS = 2305,
  parameter int LW         = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic run_next_i,
  input  logic tick_i,
  input  logic det_i,
  output logic lock_o
);
  logic [LW-1:0] cnt_q;
  logic          waited_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      waited_q <= 1'b0;
      lock_o   <= 1'b0;
    end else begin
      if (!run_i) begin
        cnt_q    <= '0;
        waited_q <= 1'b0;
      end else if (tick_i && !waited_q) begin
        if (cnt_q == LW'(LOCK_TICKS - 1)) waited_q <= 1'b1;
        else                              cnt_q    <= cnt_q + 1'b1;
      end
      lock_o <= run_next_i && waited_q && det_i;
    end
  end

  assert_lock_needs_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> run_i);
endmodule

// File: rtl/clkgen_pwrup_seq.sv
module clkgen_pwrup_seq
  import clkseq_pkg::*;
#(
  parameter int REF_TICKS  = 65536,
  parameter int FB_TICKS   = 65536,
  parameter int CAL_TICKS  = 131072,
  parameter int LOCK_TICKS = 2305
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       xtal_sel_i,
  input  logic       xtal_ok_i,
  input  logic       reset_pin_ni,
  input  logic       pdn_ni,
  input  logic       reg_rst_i,
  input  logic       ref_tick_i,
  input  logic       fb_tick_i,
  input  logic       lock_det_i,
  output logic [2:0] state_o,
  output logic       load_defaults_o,
  output logic       cal_start_o,
  output logic       out_en_o,
  output logic       lock_o
);
  localparam int MAX_AB = (REF_TICKS > FB_TICKS) ? REF_TICKS : FB_TICKS;
  localparam int MAX_T  = (MAX_AB > CAL_TICKS) ? MAX_AB : CAL_TICKS;
  localparam int CW     = $clog2(MAX_T + 1);
  localparam int LW     = $clog2(LOCK_TICKS + 1);

  seq_state_e    state;
  logic          hold, hit, cnt_clr, cnt_en, use_fb, run_next, run_q;
  logic [CW-1:0] limit;

  assign hold = !pwr_good_i || !reset_pin_ni || !pdn_ni;

  clkseq_fsm #(
    .REF_TICKS(REF_TICKS), .FB_TICKS(FB_TICKS), .CAL_TICKS(CAL_TICKS), .CW(CW)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .reg_rst_i(reg_rst_i),
    .xtal_sel_i(xtal_sel_i), .xtal_ok_i(xtal_ok_i), .hit_i(hit),
    .state_o(state), .run_next_o(run_next), .cnt_clr_o(cnt_clr),
    .cnt_en_o(cnt_en), .use_fb_o(use_fb), .limit_o(limit),
    .load_o(load_defaults_o), .cal_start_o(cal_start_o)
  );

  clkseq_tick_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .en_i(cnt_en),
    .tick_i(use_fb ? fb_tick_i : ref_tick_i), .limit_i(limit), .hit_o(hit)
  );

  assign run_q = (state == ST_RUN);

  clkseq_lock_timer #(.LOCK_TICKS(LOCK_TICKS), .LW(LW)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .run_next_i(run_next),
    .tick_i(ref_tick_i), .det_i(lock_det_i), .lock_o(lock_o)
  );

  assign state_o  = state;
  assign out_en_o = run_q;

  assert_lock_outen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> out_en_o);
  assert_cal_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> !out_en_o);
endmodule

// File: tb/clkgen_pwrup_seq_bench.sv
module clkgen_pwrup_seq_bench;
  localparam int REF_T = 20, FB_T = 15, CAL_T = 30, LOCK_T = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 0, xtal_sel = 1, xtal_ok = 0, reset_pin_n = 0, pdn_n = 0;
  logic reg_rst = 0, ref_tick = 0, fb_tick = 0, lock_det = 0;
  logic [2:0] state;
  logic load_def, cal_start, out_en, lock;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  clkgen_pwrup_seq #(
    .REF_TICKS(REF_T), .FB_TICKS(FB_T), .CAL_TICKS(CAL_T), .LOCK_TICKS(LOCK_T)
  ) u_clkgen_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .xtal_sel_i(xtal_sel),
    .xtal_ok_i(xtal_ok), .reset_pin_ni(reset_pin_n), .pdn_ni(pdn_n),
    .reg_rst_i(reg_rst), .ref_tick_i(ref_tick), .fb_tick_i(fb_tick),
    .lock_det_i(lock_det), .state_o(state), .load_defaults_o(load_def),
    .cal_start_o(cal_start), .out_en_o(out_en), .lock_o(lock)
  );

  function automatic int exp_lock(bit run, bit waited, bit det);
    return (run && waited && det) ? 1 : 0;
  endfunction

  function automatic int exp_code_after_hold(bit soft_bit);
    return soft_bit ? 1 : 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit f);
    ref_tick = r;
    fb_tick  = f;
    @(negedge clk);
    ref_tick = 0;
    fb_tick  = 0;
  endtask

  // n counted pulses on one line, random gaps, noise on the other line
  task automatic send(input int n, input bit on_fb);
    for (int i = 0; i < n; i++) begin
      int gaps = $urandom_range(0, 2);
      for (int g = 0; g < gaps; g++)
        step(on_fb ? 1'($urandom_range(0, 1)) : 1'b0,
             on_fb ? 1'b0 : 1'($urandom_range(0, 1)));
      step(on_fb ? 1'($urandom_range(0, 1)) : 1'b1,
           on_fb ? 1'b1 : 1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", state, 0);
    check("R1 reset out_en", out_en, 0);
    check("R1 reset lock", lock, 0);
    step(0, 0);
    check("R1 hold with pins low", state, 0);

    pwr_good = 1; reset_pin_n = 1; pdn_n = 1;
    step(0, 0);
    check("R2 exit hold state", state, exp_code_after_hold(0));
    check("R2 load pulse", load_def, 1);
    step(0, 0);
    check("R2 load single cycle", load_def, 0);
    repeat (4) step(1, 1);
    check("R3 waits for crystal", state, 2);
    xtal_ok = 1;
    step(0, 0);
    check("R3 crystal ok", state, 3);

    send(REF_T - 1, 0);
    check("R4 ref not done", state, 3);
    send(1, 0);
    check("R4 ref done", state, 4);

    send(FB_T - 1, 1);
    check("R5 fb not done", state, 4);
    send(1, 1);
    check("R5 fb done", state, 5);
    check("R6 cal start", cal_start, 1);
    step(0, 0);
    check("R6 cal start single", cal_start, 0);

    send(CAL_T - 1, 0);
    check("R6 cal ongoing", state, 5);
    check("R6 out_en off in cal", out_en, 0);
    send(1, 0);
    check("R7 run state", state, 6);
    check("R7 out_en immediate", out_en, 1);

    lock_det = 1;
    send(LOCK_T - 1, 0);
    check("R8 lock before window", lock, exp_lock(1, 0, 1));
    send(1, 0);
    step(0, 0);
    check("R8 lock after window", lock, exp_lock(1, 1, 1));
    lock_det = 0;
    step(0, 0);
    check("R8 lock follows det low", lock, exp_lock(1, 1, 0));
    lock_det = 1;
    step(0, 0);
    check("R8 lock follows det high", lock, exp_lock(1, 1, 1));

    reg_rst = 1;
    xtal_sel = 0;
    step(0, 0);
    check("R9 soft state", state, 1);
    check("R9 soft out_en", out_en, 0);
    check("R8 lock drops with out_en", lock, 0);
    step(0, 0);
    reg_rst = 0;
    step(0, 0);
    check("R9 soft release state", state, 2);
    check("R9 no default reload", load_def, 0);
    step(0, 0);
    check("R3 no crystal skips wait", state, 3);

    send(10, 0);
    pdn_n = 0;
    step(0, 0);
    check("R1 pdn hold", state, 0);
    pdn_n = 1;
    step(0, 0);
    check("R2 pdn release reload", load_def, 1);
    step(0, 0);
    send(REF_T - 1, 0);
    check("R10 partial count discarded", state, 3);
    send(1, 0);
    check("R10 full count", state, 4);

    for (int it = 0; it < 3; it++) begin
      int src = $urandom_range(0, 2);
      send($urandom_range(0, FB_T - 2), 1);
      if (src == 0) pwr_good = 0;
      else if (src == 1) reset_pin_n = 0;
      else pdn_n = 0;
      step(1, 1);
      check("R1 random hold source", state, 0);
      pwr_good = 1; reset_pin_n = 1; pdn_n = 1;
      step(0, 0);
      check("R2 random reload", load_def, 1);
      step(0, 0);
      send(REF_T, 0);
      check("R10 restart reaches fb", state, 4);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule